// File: doc/BRIEF.md
# Paged 48-Line GPIO Interrupt Controller

This block gives a host byte-wide register access to 48 general-purpose lines grouped as six 8-bit ports. Each port has a data register: a 1 in a bit drives that line as an output, a 0 releases it so the line can be read as an input. Reading a data register returns the line levels after a two-flop synchronizer.

The first three ports (lines 0 to 23) can raise edge-triggered interrupts. For each of these lines the block holds a polarity bit (rising or falling edge), an enable bit and a pending bit. The three banks share the top three addresses of an 11-byte window. A 2-bit page field, held in the top bits of a control byte, picks which bank those addresses reach.

A selected edge on an enabled line sets its pending bit. The single interrupt request output is high while any pending bit is also enabled. Software clears pending bits by writing ones to them through the pending page.

Top module: `pgpio_irq_ctrl`

## Requirements
- R1: Addresses above 0x0A read as 0x00, and writes to them change no line drive, polarity, enable or pending state.
- R2: A write to address p (0 to 5) loads the drive bits of port p. Data bit n controls line 8p+n: 1 drives the line and 0 releases it (pin_drive bit low).
- R3: A read of address p (0 to 5) returns the levels of lines 8p..8p+7. A change on pin_in is visible in the read data two clock edges later.
- R4: Address 0x06 reads as 0x00 and ignores writes.
- R5: Address 0x07 holds the page field in data bits 7:6. A write loads those two bits, and a read returns the page field with bits 5:0 at 0.
- R6: With page 1 selected, addresses 0x08 to 0x0A read and write the polarity bytes of ports 0 to 2. A polarity bit of 1 selects rising edges and 0 selects falling edges.
- R7: With page 2 selected, addresses 0x08 to 0x0A read and write the enable bytes of ports 0 to 2. A 1 enables the line, and writing 0x00 to all three bytes disables every interrupt.
- R8: With page 0 selected, addresses 0x08 to 0x0A read as 0x00 and ignore writes.
- R9: A selected edge on an enabled line 0..23 sets that line's pending bit on the third clock edge after pin_in changes. The pending bit is read through page 3 at addresses 0x08 to 0x0A. An edge of the other direction sets nothing.
- R10: Lines whose enable bit is 0, and lines 24 to 47, never set a pending bit and never raise irq_req.
- R11: irq_req is high exactly while some pending bit has its enable bit set. Clearing the enable drops irq_req, and the pending bit stays set.
- R12: With page 3 selected, a write to address 0x08+k clears the pending bits of port k where the written data has a 1 and leaves the other pending bits unchanged.
- R13: After reset all lines are released, the page field is 0, and polarity, enable and pending bits are all 0, so irq_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Line levels from the pads |
| pin_drive | output | 48 | Per-line drive enable; 1 drives the line |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- a data write lands on the drive bits;
- writes to the reserved byte and through page 0 leave state untouched;
- the page field loads from data bits 7:6;
- out-of-window reads give zero;
- no pending bit appears on a disabled line;
- an acknowledge clears its masked bits unless a new edge arrives in the same cycle.

Only the bench scenarios can show the rest:
- the three-edge latency from a pin change to a pending bit;
- that polarity picks the right edge direction;
- that disabling an enable masks the request without losing the pending bit;
- that partial acknowledges keep the bits that were not written.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pgpio_rst_sync.sv
module pgpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/pgpio_irq_port.sv
module pgpio_irq_port #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_s,
  input  logic             pol_we,
  input  logic             en_we,
  input  logic             ack_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] en_o,
  output logic [LINES-1:0] pend_o,
  output logic             irq_o
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] pol_q, pol_d;
  logic [LINES-1:0] en_q, en_d;
  logic [LINES-1:0] pend_q, pend_d;
  logic [LINES-1:0] rise, fall, hit, clr_mask;

  // Edge detection on the synchronized levels
  always_comb begin
    rise     = line_s & ~prev_q;
    fall     = ~line_s & prev_q;
    hit      = en_q & ((pol_q & rise) | (~pol_q & fall));
    clr_mask = ack_we ? wdata : '0;
  end

  // Next-state; a new edge wins over a same-cycle acknowledge
  always_comb begin
    pol_d  = pol_we ? wdata : pol_q;
    en_d   = en_we  ? wdata : en_q;
    pend_d = (pend_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_s;
      pol_q  <= pol_d;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign pol_o  = pol_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_q);

  // R10: a pending bit may only appear on a line that was enabled
  assert_pend_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R12: acknowledged bits are clear unless a fresh edge arrived
  assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((pend_q & $past(wdata) & ~$past(hit)) == '0));
endmodule

// File: rtl/pgpio_irq_ctrl.sv
module pgpio_irq_ctrl
  import pgpio_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_drive,
  output logic                        irq_req
);
  localparam int NLINES    = NUM_PORTS * PORT_W;
  localparam int NIRQ      = IRQ_PORTS * PORT_W;
  localparam int RSVD_ADDR = NUM_PORTS;
  localparam int PAGE_ADDR = NUM_PORTS + 1;
  localparam int BANK_BASE = NUM_PORTS + 2;
  localparam int LAST_ADDR = BANK_BASE + IRQ_PORTS - 1;

  logic              rst_i_n;
  logic [NLINES-1:0] sync_q;
  logic [NIRQ-1:0]   pol_all, en_all, pend_all;
  logic [IRQ_PORTS-1:0] irq_vec;
  page_e             page_q, page_d;
  logic [PORT_W-1:0] rdata_d;
  logic              bank_addr;

  pgpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pgpio_sync #(.WIDTH(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  // Drive registers, one per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] drv_q, drv_d;
    always_comb begin
      drv_d = drv_q;
      if (bus_wr && bus_addr == ADDR_W'(p)) drv_d = bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) drv_q <= '0;
      else          drv_q <= drv_d;
    end
    assign pin_drive[p*PORT_W +: PORT_W] = drv_q;
  end

  // Page field
  always_comb begin
    page_d = page_q;
    if (bus_wr && bus_addr == ADDR_W'(PAGE_ADDR))
      page_d = page_e'(bus_wdata[PORT_W-1 -: 2]);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) page_q <= PG_NONE;
    else          page_q <= page_d;
  end

  // Interrupt-capable ports
  for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_irq
    logic sel;
    assign sel = bus_wr && (bus_addr == ADDR_W'(BANK_BASE + i));
    pgpio_irq_port #(.LINES(PORT_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .line_s (sync_q[i*PORT_W +: PORT_W]),
      .pol_we (sel && page_q == PG_POL),
      .en_we  (sel && page_q == PG_EN),
      .ack_we (sel && page_q == PG_ID),
      .wdata  (bus_wdata),
      .pol_o  (pol_all[i*PORT_W +: PORT_W]),
      .en_o   (en_all[i*PORT_W +: PORT_W]),
      .pend_o (pend_all[i*PORT_W +: PORT_W]),
      .irq_o  (irq_vec[i])
    );
  end

  assign irq_req = |irq_vec;

  // Read decode
  always_comb begin
    rdata_d = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_addr == ADDR_W'(p)) rdata_d = sync_q[p*PORT_W +: PORT_W];
    if (bus_addr == ADDR_W'(PAGE_ADDR)) rdata_d = {page_q, {(PORT_W-2){1'b0}}};
    for (int b = 0; b < IRQ_PORTS; b++) begin
      if (bus_addr == ADDR_W'(BANK_BASE + b)) begin
        case (page_q)
          PG_POL:  rdata_d = pol_all[b*PORT_W +: PORT_W];
          PG_EN:   rdata_d = en_all[b*PORT_W +: PORT_W];
          PG_ID:   rdata_d = pend_all[b*PORT_W +: PORT_W];
          default: rdata_d = '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_d;
  assign bank_addr = (bus_addr >= ADDR_W'(BANK_BASE)) && (bus_addr <= ADDR_W'(LAST_ADDR));

  // R1: nothing is readable past the window
  assert_oob_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_addr > ADDR_W'(LAST_ADDR)) |-> (bus_rdata == '0));

  // R2: a write to port 0 lands on its drive bits
  assert_drive_load_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bus_addr == '0) |=> (pin_drive[PORT_W-1:0] == $past(bus_wdata)));

  // R4: the reserved byte ignores writes
  assert_rsvd_write_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bus_addr == ADDR_W'(RSVD_ADDR)) |=> $stable(pin_drive));

  // R5: page field comes from the top two data bits
  assert_page_load_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bus_addr == ADDR_W'(PAGE_ADDR)) |=> (page_q == $past(bus_wdata[PORT_W-1 -: 2])));

  // R8: page 0 writes leave polarity and enable untouched
  assert_page0_ignored_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bank_addr && page_q == PG_NONE) |=> ($stable(pol_all) && $stable(en_all)));
endmodule

// File: tb/pgpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pgpio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_drive;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgpio_irq_ctrl u_pgpio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_drive (pin_drive),
    .irq_req   (irq_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pin_set(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R13 drive", pin_drive, 48'h0);
    chk("R13 irq", irq_req, 1'b0);
    rd(8'h07, d); chk("R13 page", d, 8'h00);
    wr(8'h07, 8'h40); rd(8'h08, d); chk("R13 polarity", d, 8'h00);
    wr(8'h07, 8'h80); rd(8'h09, d); chk("R13 enable", d, 8'h00);
    wr(8'h07, 8'hC0); rd(8'h0A, d); chk("R13 pending", d, 8'h00);
    wr(8'h07, 8'h00);
  endtask

  task automatic t_data;
    logic [7:0] d;
    wr(8'h00, 8'hA5); wr(8'h05, 8'h3C); wr(8'h02, 8'hFF); wr(8'h02, 8'h01);
    chk("R2 port0", pin_drive[7:0], 8'hA5);
    chk("R2 port5", pin_drive[47:40], 8'h3C);
    chk("R2 port2 rewrite", pin_drive[23:16], 8'h01);
    @(negedge clk); pin_in[15:8] = 8'h96; pin_in[39:32] = 8'h5A;
    edges(2);
    rd(8'h01, d); chk("R3 port1 levels", d, 8'h96);
    rd(8'h04, d); chk("R3 port4 levels", d, 8'h5A);
    @(negedge clk); pin_in = '0;
    edges(3);
  endtask

  task automatic t_window;
    logic [7:0] d;
    wr(8'h0B, 8'hFF); wr(8'hFF, 8'hFF);
    chk("R1 oob write", pin_drive, {8'h3C, 8'h00, 8'h00, 8'h01, 8'h00, 8'hA5});
    rd(8'h0C, d); chk("R1 oob read", d, 8'h00);
    wr(8'h06, 8'hFF);
    chk("R4 reserved write", pin_drive, {8'h3C, 8'h00, 8'h00, 8'h01, 8'h00, 8'hA5});
    rd(8'h06, d); chk("R4 reserved read", d, 8'h00);
    wr(8'h07, 8'hFF); rd(8'h07, d); chk("R5 page readback", d, 8'hC0);
    wr(8'h07, 8'h00); wr(8'h08, 8'hFF); wr(8'h09, 8'hFF);
    rd(8'h08, d); chk("R8 page0 read", d, 8'h00);
    wr(8'h07, 8'h40); rd(8'h08, d); chk("R8 polarity untouched", d, 8'h00);
    wr(8'h07, 8'h80); rd(8'h09, d); chk("R8 enable untouched", d, 8'h00);
    wr(8'h07, 8'h00);
    rd(8'h0B, d); chk("R1 oob after page write", d, 8'h00);
  endtask

  task automatic t_banks;
    logic [7:0] d;
    wr(8'h07, 8'h40);
    wr(8'h08, 8'h5A); wr(8'h09, 8'hC3); wr(8'h0A, 8'h81);
    rd(8'h08, d); chk("R6 pol port0", d, 8'h5A);
    rd(8'h09, d); chk("R6 pol port1", d, 8'hC3);
    rd(8'h0A, d); chk("R6 pol port2", d, 8'h81);
    wr(8'h07, 8'h80);
    wr(8'h08, 8'h11); wr(8'h09, 8'h22); wr(8'h0A, 8'h44);
    rd(8'h08, d); chk("R7 en port0", d, 8'h11);
    rd(8'h09, d); chk("R7 en port1", d, 8'h22);
    rd(8'h0A, d); chk("R7 en port2", d, 8'h44);
    wr(8'h08, 8'h00); wr(8'h09, 8'h00); wr(8'h0A, 8'h00);
    rd(8'h0A, d); chk("R7 disable all", d, 8'h00);
    chk("R7 irq low", irq_req, 1'b0);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    wr(8'h07, 8'h40); wr(8'h08, 8'h01);   // line0 rising, line1 falling
    pin_set(1, 1'b1); edges(3);
    wr(8'h07, 8'h80); wr(8'h08, 8'h03);
    wr(8'h07, 8'hC0);
    rd(8'h08, d); chk("R9 nothing pending yet", d, 8'h00);
    pin_set(0, 1'b1);
    edges(2); chk("R9 irq not before third edge", irq_req, 1'b0);
    edges(1); chk("R9 irq on third edge", irq_req, 1'b1);
    rd(8'h08, d); chk("R9 rising pending", d, 8'h01);
    wr(8'h08, 8'h01);
    rd(8'h08, d); chk("R12 ack clears", d, 8'h00);
    chk("R12 irq after ack", irq_req, 1'b0);
    pin_set(0, 1'b0); edges(3);
    rd(8'h08, d); chk("R9 wrong direction ignored", d, 8'h00);
    pin_set(1, 1'b0); edges(3);
    rd(8'h08, d); chk("R9 falling pending", d, 8'h02);
    chk("R9 irq falling", irq_req, 1'b1);
    wr(8'h08, 8'h02);
    pin_set(1, 1'b1); edges(3);
    pin_set(0, 1'b1); pin_set(1, 1'b0); edges(4);
    rd(8'h08, d); chk("R12 two pending", d, 8'h03);
    wr(8'h08, 8'h01);
    rd(8'h08, d); chk("R12 partial ack", d, 8'h02);
    chk("R11 irq with one pending", irq_req, 1'b1);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(8'h07, 8'h80); wr(8'h08, 8'h01);
    chk("R11 disable drops irq", irq_req, 1'b0);
    wr(8'h07, 8'hC0);
    rd(8'h08, d); chk("R11 pending kept", d, 8'h02);
    wr(8'h07, 8'h80); wr(8'h08, 8'h03);
    chk("R11 re-enable raises irq", irq_req, 1'b1);
    wr(8'h07, 8'hC0); wr(8'h08, 8'hFF);
    chk("R11 irq after full ack", irq_req, 1'b0);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(8'h07, 8'h40); wr(8'h09, 8'hFF);
    pin_set(8, 1'b1); edges(3);
    pin_set(8, 1'b0); edges(3);
    wr(8'h07, 8'hC0);
    rd(8'h09, d); chk("R10 disabled line", d, 8'h00);
    pin_set(30, 1'b1); edges(3);
    pin_set(30, 1'b0); edges(3);
    chk("R10 upper line no irq", irq_req, 1'b0);
    rd(8'h0A, d); chk("R10 port2 none", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_data();
    t_window();
    t_banks();
    t_edges();
    t_mask();
    t_disabled();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule